// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

This block picks one of two reference clocks with a single select line and feeds the chosen clock to two output banks, A and B. Each bank divides the clock by a ratio chosen by its own 3-bit code. Each bank drives two copies of the divided clock. Divide-by-one passes the source clock straight through. Odd ratios keep a 50% duty cycle by adding a copy of the divider's high phase that is delayed to the falling edge.

Each bank also has an output enable. The block does not drive `'z` internally. It hands every output bit to a pad cell as a data bit plus an active-high drive enable, and the pad is in high impedance while the enable is low. A new ratio code is taken in only when the bank's current divided period ends, so a ratio change never produces a short pulse.

The select line is meant to be changed only while reset is held. The source mux is a plain combinational switch.

Top module: `clk_fanout_div`

## Requirements
- R1: The 3-bit ratio code of a bank selects the output period in source-clock cycles: 000=1, 001=2, 010=3, 011=4, 100=5, 101=6, 110=8, 111=16.
- R2: For every ratio N, the bank output is high for exactly N source half-periods and low for N half-periods, which gives a 50% duty cycle for odd N as well. With code 000 the output follows the source clock.
- R3: Both output bits of a bank always carry the same value.
- R4: With `clk_sel_i` low the banks run from `clk0_i`. With it high they run from `clk1_i`. The output period is measured in time against the selected clock.
- R5: `qa_en_o` (both bits) equals `oe_a_i`, and `qb_en_o` equals `oe_b_i`. A low enable means the pad is in high impedance. One bank's enable has no effect on the other bank's enable.
- R6: The two banks divide independently: different codes on A and B give each bank its own period at the same time.
- R7: A ratio code change is applied only at the end of the current divided period. The period in progress completes with its old high and low times, and the next period uses the new ratio.
- R8: While `rst_ni` is low, all data outputs are low. For non-bypass ratios, both banks go high on the first rising source edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0_i | input | 1 | Reference clock 0 (selected when clk_sel_i is low) |
| clk1_i | input | 1 | Reference clock 1 (selected when clk_sel_i is high) |
| clk_sel_i | input | 1 | Source select |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ratio_a_i | input | 3 | Bank A ratio code |
| ratio_b_i | input | 3 | Bank B ratio code |
| oe_a_i | input | 1 | Bank A output enable |
| oe_b_i | input | 1 | Bank B output enable |
| qa_o | output | 2 | Bank A divided clock, two copies |
| qa_en_o | output | 2 | Bank A pad drive enables |
| qb_o | output | 2 | Bank B divided clock, two copies |
| qb_en_o | output | 2 | Bank B pad drive enables |

## Verification
A ratio code write can fall in the same source cycle in which the divider counter wraps. In that cycle the period restart and the load of the new ratio happen on one edge, and the new high-time threshold must come from the incoming code, not the outgoing one. The bench provokes this by writing a short ratio into a bank running at divide-by-16 just after the output rises. It then requires the current high and low phases to keep 16 half-periods each and the next period to show the new high time. A second overlap is the reset release: two banks on different odd and even ratios must both rise on the same first edge.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CODE_W = 3;
  localparam int CNT_W  = 4;   // holds ratio-1 for the largest ratio (16)

  function automatic logic [CNT_W:0] ratio_of(input logic [CODE_W-1:0] code);
    logic [CNT_W:0] n;
    case (code)
      3'd0:    n = 5'd1;
      3'd1:    n = 5'd2;
      3'd2:    n = 5'd3;
      3'd3:    n = 5'd4;
      3'd4:    n = 5'd5;
      3'd5:    n = 5'd6;
      3'd6:    n = 5'd8;
      default: n = 5'd16;
    endcase
    return n;
  endfunction

  // cycles the rising-edge phase stays high: N/2 for even, (N-1)/2 for odd
  function automatic logic [CNT_W-1:0] hi_of(input logic [CODE_W-1:0] code);
    logic [CNT_W:0] n;
    n = ratio_of(code);
    return n[CNT_W:1];
  endfunction
endpackage

// File: rtl/clk_src_mux.sv
module clk_src_mux (
  input  logic clk0_i,
  input  logic clk1_i,
  input  logic sel_i,
  output logic clk_o
);
  assign clk_o = sel_i ? clk1_i : clk0_i;
endmodule

// File: rtl/ratio_dec.sv
module ratio_dec
  import clkdiv_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  term_o,
  output logic              odd_o,
  output logic              bypass_o
);
  logic [CNT_W:0] n;
  logic [CNT_W:0] n_m1;

  always_comb begin
    n        = ratio_of(code_i);
    n_m1     = n - 1'b1;
    term_o   = n_m1[CNT_W-1:0];
    odd_o    = n[0] & (n != 1);
    bypass_o = (n == 1);
  end
endmodule

// File: rtl/bank_div.sv
module bank_div
  import clkdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              q_o
);
  logic [CNT_W-1:0]  cnt_q, cnt_nxt, act_term, nxt_hi;
  logic [CODE_W-1:0] act_q;
  logic              act_odd, act_bypass, wrap;
  logic              pos_q, neg_q, run_q;

  ratio_dec u_dec (
    .code_i  (act_q),
    .term_o  (act_term),
    .odd_o   (act_odd),
    .bypass_o(act_bypass)
  );

  always_comb begin
    wrap    = (cnt_q == act_term);
    cnt_nxt = wrap ? '0 : cnt_q + 1'b1;
    // threshold of the period about to start: new code if loaded this edge
    nxt_hi  = wrap ? hi_of(code_i) : hi_of(act_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= '0;
      pos_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (wrap) act_q <= code_i;
      pos_q <= (cnt_nxt < nxt_hi);
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      neg_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      neg_q <= pos_q;
      run_q <= 1'b1;
    end
  end

  assign q_o = act_bypass ? (clk_i & run_q) : (pos_q | (act_odd & neg_q));
endmodule

// File: rtl/clk_fanout_div.sv
module clk_fanout_div
  import clkdiv_pkg::*;
#(
  parameter int FANOUT = 2
) (
  input  logic              clk0_i,
  input  logic              clk1_i,
  input  logic              clk_sel_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] ratio_a_i,
  input  logic [CODE_W-1:0] ratio_b_i,
  input  logic              oe_a_i,
  input  logic              oe_b_i,
  output logic [FANOUT-1:0] qa_o,
  output logic [FANOUT-1:0] qa_en_o,
  output logic [FANOUT-1:0] qb_o,
  output logic [FANOUT-1:0] qb_en_o
);
  localparam int NBANK = 2;

  logic                           src_clk;
  logic [NBANK-1:0][CODE_W-1:0]   code;
  logic [NBANK-1:0]               oe, div_q;
  logic [NBANK-1:0][FANOUT-1:0]   q_fan, en_fan;

  clk_src_mux u_mux (
    .clk0_i(clk0_i),
    .clk1_i(clk1_i),
    .sel_i (clk_sel_i),
    .clk_o (src_clk)
  );

  assign code = {ratio_b_i, ratio_a_i};
  assign oe   = {oe_b_i, oe_a_i};

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    bank_div u_div (
      .clk_i (src_clk),
      .rst_ni(rst_ni),
      .code_i(code[b]),
      .q_o   (div_q[b])
    );
    assign q_fan[b]  = {FANOUT{div_q[b]}};
    assign en_fan[b] = {FANOUT{oe[b]}};
  end

  assign qa_o    = q_fan[0];
  assign qb_o    = q_fan[1];
  assign qa_en_o = en_fan[0];
  assign qb_en_o = en_fan[1];
endmodule

// File: rtl/bank_div_chk.sv
module bank_div_chk
  import clkdiv_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  act_term,
  input logic [CODE_W-1:0] act_q,
  input logic              act_bypass,
  input logic              q_o
);
  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= act_term);

  p_load_at_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q != $past(act_q)) |-> ($past(cnt_q) == $past(act_term)));

  p_period_start_high_r2: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !act_bypass) |-> q_o);

  p_period_end_low_r2: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (cnt_q == act_term && !act_bypass) |-> !q_o);
endmodule

bind bank_div bank_div_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnt_q     (cnt_q),
  .act_term  (act_term),
  .act_q     (act_q),
  .act_bypass(act_bypass),
  .q_o       (q_o)
);

// File: tb/clk_fanout_div_tb_top.sv
`timescale 1ns/1ps
module clk_fanout_div_tb_top;
  logic clk0 = 1'b0, clk1 = 1'b0, sel = 1'b0, rst_n = 1'b0;
  logic [2:0] ra = 3'd0, rb = 3'd0;
  logic oea = 1'b1, oeb = 1'b1;
  logic [1:0] qa, qa_en, qb, qb_en;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  localparam real T0 = 5.0;
  localparam real T1 = 8.0;

  always #(T0/2) clk0 = ~clk0;
  always #(T1/2) clk1 = ~clk1;

  clk_fanout_div dut_i (
    .clk0_i(clk0), .clk1_i(clk1), .clk_sel_i(sel), .rst_ni(rst_n),
    .ratio_a_i(ra), .ratio_b_i(rb), .oe_a_i(oea), .oe_b_i(oeb),
    .qa_o(qa), .qa_en_o(qa_en), .qb_o(qb), .qb_en_o(qb_en)
  );

  function automatic int ratio_exp(input int c);
    int t[8] = '{1, 2, 3, 4, 5, 6, 8, 16};
    return t[c];
  endfunction

  task automatic check(input bit ok, input string req, input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // wait for the next edge of the selected source, then settle
  task automatic step();
    if (sel) @(posedge clk1 or negedge clk1);
    else     @(posedge clk0 or negedge clk0);
    #1;
  endtask

  function automatic logic qbit(input int b);
    return b ? qb[0] : qa[0];
  endfunction

  function automatic bit fan_ok(input int b);
    return b ? (qb[0] === qb[1]) : (qa[0] === qa[1]);
  endfunction

  task automatic measure(input int b, output int h, output int l,
                         output real per, output bit fan);
    int g = 0;
    real t0;
    fan = 1'b1;
    while (qbit(b) !== 1'b0 && g < 80) begin step(); g++; end
    while (qbit(b) !== 1'b1 && g < 160) begin step(); g++; end
    t0 = $realtime;
    h = 0;
    while (qbit(b) === 1'b1 && h < 80) begin
      if (!fan_ok(b)) fan = 1'b0;
      h++; step();
    end
    l = 0;
    while (qbit(b) === 1'b0 && l < 80) begin
      if (!fan_ok(b)) fan = 1'b0;
      l++; step();
    end
    per = $realtime - t0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) step();
    if (sel) @(negedge clk1); else @(negedge clk0);
    #0.5;
    rst_n = 1'b1;
  endtask

  initial begin
    #200us;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
    end
  end

  initial begin
    int h, l, hb, lb;
    real per, perb;
    bit fan, fanb;

    // R8: reset state and in-phase start of two banks (odd and even ratio)
    ra = 3'd2; rb = 3'd3;
    repeat (3) @(negedge clk0);
    #1;
    check(qa === 2'b00 && qb === 2'b00, "R8 outputs low in reset", real'(qa|qb), 0);
    @(negedge clk0); #0.5; rst_n = 1'b1;
    #1;
    check(qa[0] === 1'b0 && qb[0] === 1'b0, "R8 low before first edge", real'(qa[0]|qb[0]), 0);
    @(posedge clk0); #1;
    check(qa[0] === 1'b1 && qb[0] === 1'b1, "R8 both banks rise together",
          real'(qa[0] & qb[0]), 1);

    // R1 R2 R3 R4 R6: full code sweep, both sources, both banks at once
    for (int s = 0; s < 2; s++) begin
      sel = s[0];
      do_reset();
      for (int c = 0; c < 8; c++) begin
        int na, nb;
        real tp;
        ra = c[2:0]; rb = 3'(7 - c);
        na = ratio_exp(c); nb = ratio_exp(7 - c);
        tp = s ? T1 : T0;
        measure(0, h, l, per, fan);
        measure(0, h, l, per, fan);
        check(h == na && l == na, "R2 bank A high/low half-periods", h * 100 + l, na * 101);
        check(per > na * tp - 0.01 && per < na * tp + 0.01, "R1 R4 bank A period", per, na * tp);
        check(fan, "R3 bank A copies equal", fan, 1);
        measure(1, hb, lb, perb, fanb);
        measure(1, hb, lb, perb, fanb);
        check(hb == nb && lb == nb, "R6 R2 bank B high/low half-periods", hb * 100 + lb, nb * 101);
        check(perb > nb * tp - 0.01 && perb < nb * tp + 0.01, "R6 R4 bank B period", perb, nb * tp);
        check(fanb, "R3 bank B copies equal", fanb, 1);
      end
    end

    // R7: code change mid-period waits for the period boundary
    sel = 1'b0;
    do_reset();
    ra = 3'd7;
    measure(0, h, l, per, fan);
    while (qa[0] !== 1'b0) step();
    while (qa[0] !== 1'b1) step();
    ra = 3'd1;
    h = 0;
    while (qa[0] === 1'b1 && h < 80) begin h++; step(); end
    l = 0;
    while (qa[0] === 1'b0 && l < 80) begin l++; step(); end
    check(h == 16 && l == 16, "R7 current period keeps old ratio", h * 100 + l, 1616);
    h = 0;
    while (qa[0] === 1'b1 && h < 80) begin h++; step(); end
    check(h == 2, "R7 next period uses new ratio", h, 2);

    // R5: output enables per bank
    oea = 1'b0; oeb = 1'b1; #1;
    check(qa_en === 2'b00 && qb_en === 2'b11, "R5 bank A disabled only", real'({qa_en, qb_en}), 3);
    oea = 1'b1; oeb = 1'b0; #1;
    check(qa_en === 2'b11 && qb_en === 2'b00, "R5 bank B disabled only", real'({qa_en, qb_en}), 12);
    oea = 1'b1; oeb = 1'b1; #1;
    check(qa_en === 2'b11 && qb_en === 2'b11, "R5 both enabled", real'({qa_en, qb_en}), 15);

    done = 1'b1;
    summary();
  end
endmodule